// File: doc/BRIEF.md
# Fall-Through Audio FIFO Pair

This block holds the sample queues between a host and a codec serial shifter. It has one transmit queue and one receive queue. Each queue is a chain of slots. A slot carries a valid bit and one 16-bit word. A word enters at the top slot and drops one slot per clock while any slot below it is free, so it comes to rest in the lowest slot that holds no valid data. When the bottom word is removed, every entry above it drops by one slot on the same clock.

The host writes samples into the top of the transmit queue and reads samples from the bottom of the receive queue through a registered read port. The shifter pops words from the bottom of the transmit queue and pushes words into the top of the receive queue. A 12-bit audio sample is left-justified in the word. The block does not interpret the word, so all 16 bits pass through unchanged.

Each queue has a registered level flag. The transmit flag is set while the queue holds half its depth or fewer entries. The receive flag is set while it holds half or more. Each flag has its own mask input, and the interrupt output is the OR of the masked flags. Three sticky error flags are provided: a host write to a full transmit queue, a shifter push into a full receive queue, and a host read with no word at the receive bottom. These flags clear only on reset.

Top module: `audio_fifo_pair`

## Requirements
- R1: A host write (`host_wr_en` high at a clock edge) puts the word in the top transmit slot, and the word then drops one slot per clock. In an empty queue of depth 8, `sh_tx_valid` rises exactly 7 clocks after the write edge.
- R2: Both queues deliver words in the order they entered, with all 16 bits unchanged, including the low four bits below a left-justified 12-bit sample.
- R3: A host read (`host_rd_en` high at an edge) loads the bottom receive word into `host_rd_data` at that edge and removes it. All remaining entries drop one slot on the same edge, so reads on consecutive clocks return consecutive entries. `host_rd_data` holds its value while no read is made.
- R4: `tx_level_flag` is 1 whenever the transmit queue holds at most DEPTH/2 (4) entries, counting words still falling. It reflects the contents after each edge and is 1 after reset.
- R5: `rx_level_flag` is 1 whenever the receive queue holds at least DEPTH/2 (4) entries, counting words still falling. It is 0 after reset.
- R6: A host write when all 8 transmit slots are valid and none is being popped is discarded, and `tx_overrun` goes to 1 and stays 1 until reset.
- R7: `sh_tx_pop` removes the bottom transmit word shown on `sh_tx_data`/`sh_tx_valid`. A pop while `sh_tx_valid` is 0 has no effect on the queue contents.
- R8: A shifter push (`sh_rx_push`) into a full receive queue is discarded and sets the sticky `rx_overrun`.
- R9: A host read while the bottom receive slot is empty returns 0 in `host_rd_data` and sets the sticky `rx_underrun`.
- R10: `irq` equals (`rx_level_flag` AND `rx_mask`) OR (`tx_level_flag` AND `tx_mask`), combinationally and with no latching. A mask of 0 removes its flag from `irq`.
- R11: After reset both queues are empty, `host_rd_data` is 0 and all three sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe to transmit top |
| host_wr_data | input | 16 | Host write word |
| host_rd_en | input | 1 | Host read strobe from receive bottom |
| host_rd_data | output | 16 | Registered host read word |
| sh_tx_pop | input | 1 | Shifter removes the bottom transmit word |
| sh_tx_data | output | 16 | Bottom transmit word |
| sh_tx_valid | output | 1 | Bottom transmit slot holds a word |
| sh_rx_push | input | 1 | Shifter push into receive top |
| sh_rx_data | input | 16 | Shifter receive word |
| rx_mask | input | 1 | Enables the receive flag onto irq |
| tx_mask | input | 1 | Enables the transmit flag onto irq |
| rx_level_flag | output | 1 | Receive half-full-or-more |
| tx_level_flag | output | 1 | Transmit half-full-or-less |
| tx_overrun | output | 1 | Sticky: host write dropped |
| rx_overrun | output | 1 | Sticky: shifter push dropped |
| rx_underrun | output | 1 | Sticky: host read with empty bottom |
| irq | output | 1 | Masked level interrupt |

## Verification
The assertions assume that all strobes and masks are known, 0 or 1, in every cycle after reset. They also assume that the shifter pops only in response to the `sh_tx_valid` it sees in the same cycle, and that `sh_tx_data` is sampled only while `sh_tx_valid` is high. The bench keeps to these assumptions by changing every input at the falling clock edge and by releasing every strobe after one edge. Pops of an empty queue are issued only on purpose, while `sh_tx_valid` is low, to exercise R7.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

    parameter int AUD_W          = 16;
    parameter int AUD_DEPTH_DFLT = 8;

    typedef struct packed {
        logic             valid;
        logic [AUD_W-1:0] word;
    } aud_slot_t;

    typedef enum logic {
        LVL_AT_LEAST = 1'b0,
        LVL_AT_MOST  = 1'b1
    } lvl_mode_e;

    function automatic int fill_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/audio_fall_chain.sv
module audio_fall_chain
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH = AUD_DEPTH_DFLT,
    localparam int CNT_W = fill_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [AUD_W-1:0] push_word,
    input  logic             pop,
    output logic [AUD_W-1:0] bot_word,
    output logic             bot_valid,
    output logic             dropped,
    output logic [CNT_W-1:0] fill_next
);

    aud_slot_t slot_q [DEPTH];
    aud_slot_t slot_d [DEPTH];

    logic [DEPTH-1:0]  live;      // occupancy once the pop is applied
    logic [DEPTH-1:0]  gap_le;    // a free slot at or below index i
    logic [DEPTH-1:0]  src_v;     // something waiting just above slot i
    logic [DEPTH-1:0]  fall_in;   // slot i takes the word above it
    logic [DEPTH-1:0]  fall_out;  // slot i hands its word down
    logic [AUD_W-1:0]  src_w [DEPTH];

    assign bot_word  = slot_q[0].word;
    assign bot_valid = slot_q[0].valid;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live[i] = slot_q[i].valid;
        end
        live[0] = slot_q[0].valid & ~pop;

        gap_le[0] = ~live[0];
        for (int i = 1; i < DEPTH; i++) begin
            gap_le[i] = gap_le[i-1] | ~live[i];
        end

        for (int i = 0; i < DEPTH - 1; i++) begin
            src_v[i] = live[i+1];
            src_w[i] = slot_q[i+1].word;
        end
        src_v[DEPTH-1] = push;
        src_w[DEPTH-1] = push_word;

        for (int i = 0; i < DEPTH; i++) begin
            fall_in[i] = gap_le[i] & src_v[i];
        end

        fall_out[0] = 1'b0;
        for (int i = 1; i < DEPTH; i++) begin
            fall_out[i] = fall_in[i-1];
        end

        dropped = push & ~gap_le[DEPTH-1];
    end

    always_comb begin
        fill_next = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (fall_in[i]) begin
                slot_d[i].valid = 1'b1;
                slot_d[i].word  = src_w[i];
            end else if (fall_out[i]) begin
                slot_d[i].valid = 1'b0;
                slot_d[i].word  = slot_q[i].word;
            end else begin
                slot_d[i].valid = live[i];
                slot_d[i].word  = slot_q[i].word;
            end
            fill_next = fill_next + CNT_W'(slot_d[i].valid);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[g] <= '0;
                end else begin
                    slot_q[g] <= slot_d[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/audio_level_flag.sv
module audio_level_flag
    import audio_fifo_pkg::*;
#(
    parameter int        CNT_W  = 4,
    parameter int        THRESH = 4,
    parameter lvl_mode_e MODE   = LVL_AT_LEAST,
    localparam logic     RST_VAL = (MODE == LVL_AT_MOST) ? 1'b1 : (THRESH == 0)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill_next,
    output logic             flag_q
);

    logic hit;

    generate
        if (MODE == LVL_AT_LEAST) begin : g_least
            assign hit = (fill_next >= CNT_W'(THRESH));
        end else begin : g_most
            assign hit = (fill_next <= CNT_W'(THRESH));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= RST_VAL;
        end else begin
            flag_q <= hit;
        end
    end

endmodule

// File: rtl/audio_irq_gate.sv
module audio_irq_gate #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] masks,
    output logic             irq
);

    assign irq = |(flags & masks);

endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH = AUD_DEPTH_DFLT,
    localparam int CNT_W = fill_width(DEPTH),
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr_en,
    input  logic [AUD_W-1:0] host_wr_data,
    input  logic             host_rd_en,
    output logic [AUD_W-1:0] host_rd_data,
    input  logic             sh_tx_pop,
    output logic [AUD_W-1:0] sh_tx_data,
    output logic             sh_tx_valid,
    input  logic             sh_rx_push,
    input  logic [AUD_W-1:0] sh_rx_data,
    input  logic             rx_mask,
    input  logic             tx_mask,
    output logic             rx_level_flag,
    output logic             tx_level_flag,
    output logic             tx_overrun,
    output logic             rx_overrun,
    output logic             rx_underrun,
    output logic             irq
);

    logic [AUD_W-1:0] rx_bot_word;
    logic             rx_bot_valid;
    logic             tx_drop;
    logic             rx_drop;
    logic [CNT_W-1:0] tx_fill_next;
    logic [CNT_W-1:0] rx_fill_next;

    audio_fall_chain #(.DEPTH(DEPTH)) tx_chain (
        .clk       (clk),
        .rst       (rst),
        .push      (host_wr_en),
        .push_word (host_wr_data),
        .pop       (sh_tx_pop),
        .bot_word  (sh_tx_data),
        .bot_valid (sh_tx_valid),
        .dropped   (tx_drop),
        .fill_next (tx_fill_next)
    );

    audio_fall_chain #(.DEPTH(DEPTH)) rx_chain (
        .clk       (clk),
        .rst       (rst),
        .push      (sh_rx_push),
        .push_word (sh_rx_data),
        .pop       (host_rd_en),
        .bot_word  (rx_bot_word),
        .bot_valid (rx_bot_valid),
        .dropped   (rx_drop),
        .fill_next (rx_fill_next)
    );

    audio_level_flag #(.CNT_W(CNT_W), .THRESH(HALF), .MODE(LVL_AT_MOST)) tx_lvl (
        .clk       (clk),
        .rst       (rst),
        .fill_next (tx_fill_next),
        .flag_q    (tx_level_flag)
    );

    audio_level_flag #(.CNT_W(CNT_W), .THRESH(HALF), .MODE(LVL_AT_LEAST)) rx_lvl (
        .clk       (clk),
        .rst       (rst),
        .fill_next (rx_fill_next),
        .flag_q    (rx_level_flag)
    );

    audio_irq_gate #(.N_SRC(2)) irq_or (
        .flags ({rx_level_flag, tx_level_flag}),
        .masks ({rx_mask, tx_mask}),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rd_data <= '0;
            rx_underrun  <= 1'b0;
            tx_overrun   <= 1'b0;
            rx_overrun   <= 1'b0;
        end else begin
            if (host_rd_en) begin
                host_rd_data <= rx_bot_valid ? rx_bot_word : '0;
                if (!rx_bot_valid) begin
                    rx_underrun <= 1'b1;
                end
            end
            if (tx_drop) begin
                tx_overrun <= 1'b1;
            end
            if (rx_drop) begin
                rx_overrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/audio_fifo_pair_chk.sv
module audio_fifo_pair_chk
    import audio_fifo_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_rd_en,
    input logic [AUD_W-1:0] host_rd_data,
    input logic             sh_tx_pop,
    input logic             sh_tx_valid,
    input logic [AUD_W-1:0] sh_tx_data,
    input logic             rx_mask,
    input logic             tx_mask,
    input logic             irq,
    input logic             tx_overrun,
    input logic             rx_overrun,
    input logic             rx_underrun,
    input logic             rx_bot_valid
);

    // R10
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_mask && !tx_mask) |-> !irq);

    // R9
    underrun_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && !rx_bot_valid) |=> (host_rd_data == '0 && rx_underrun));

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_underrun |=> rx_underrun);

    // R6
    tx_overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tx_overrun |=> tx_overrun);

    // R8
    rx_overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun);

    // R7
    tx_bottom_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_tx_valid && !sh_tx_pop) |=> (sh_tx_valid && $stable(sh_tx_data)));

    // R3
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd_en |=> $stable(host_rd_data));

endmodule

bind audio_fifo_pair audio_fifo_pair_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .sh_tx_pop    (sh_tx_pop),
    .sh_tx_valid  (sh_tx_valid),
    .sh_tx_data   (sh_tx_data),
    .rx_mask      (rx_mask),
    .tx_mask      (tx_mask),
    .irq          (irq),
    .tx_overrun   (tx_overrun),
    .rx_overrun   (rx_overrun),
    .rx_underrun  (rx_underrun),
    .rx_bot_valid (rx_bot_valid)
);

// File: tb/audio_fifo_pair_test.sv
`timescale 1ns/1ps
module audio_fifo_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [15:0] host_rd_data;
    logic        sh_tx_pop = 1'b0;
    logic [15:0] sh_tx_data;
    logic        sh_tx_valid;
    logic        sh_rx_push = 1'b0;
    logic [15:0] sh_rx_data = '0;
    logic        rx_mask = 1'b0;
    logic        tx_mask = 1'b0;
    logic        rx_level_flag;
    logic        tx_level_flag;
    logic        tx_overrun;
    logic        rx_overrun;
    logic        rx_underrun;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    audio_fifo_pair uut (
        .clk           (clk),
        .rst           (rst),
        .host_wr_en    (host_wr_en),
        .host_wr_data  (host_wr_data),
        .host_rd_en    (host_rd_en),
        .host_rd_data  (host_rd_data),
        .sh_tx_pop     (sh_tx_pop),
        .sh_tx_data    (sh_tx_data),
        .sh_tx_valid   (sh_tx_valid),
        .sh_rx_push    (sh_rx_push),
        .sh_rx_data    (sh_rx_data),
        .rx_mask       (rx_mask),
        .tx_mask       (tx_mask),
        .rx_level_flag (rx_level_flag),
        .tx_level_flag (tx_level_flag),
        .tx_overrun    (tx_overrun),
        .rx_overrun    (rx_overrun),
        .rx_underrun   (rx_underrun),
        .irq           (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            $display("FAIL watchdog expired: actual %0d cycles, expected under 20000", cycles);
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr_tx(input logic [15:0] d);
        host_wr_en = 1'b1;
        host_wr_data = d;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic push_rx(input logic [15:0] d);
        sh_rx_push = 1'b1;
        sh_rx_data = d;
        tick();
        sh_rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        sh_tx_pop = 1'b1;
        tick();
        sh_tx_pop = 1'b0;
    endtask

    task automatic rd_rx();
        host_rd_en = 1'b1;
        tick();
        host_rd_en = 1'b0;
    endtask

    function automatic logic [15:0] tx_word(input int i);
        return 16'hA5C3 + 16'(i) * 16'h1011;
    endfunction

    function automatic logic [15:0] rx_word(input int i);
        return 16'h8009 + 16'(i) * 16'h1111;
    endfunction

    task automatic t_reset();
        check(sh_tx_valid == 1'b0, "R11 tx empty after reset", 16'(sh_tx_valid), 16'h0);
        check(host_rd_data == 16'h0, "R11 rd data after reset", host_rd_data, 16'h0);
        check(tx_level_flag == 1'b1, "R4 tx flag after reset", 16'(tx_level_flag), 16'h1);
        check(rx_level_flag == 1'b0, "R5 rx flag after reset", 16'(rx_level_flag), 16'h0);
        check({tx_overrun, rx_overrun, rx_underrun} == 3'b000, "R11 sticky flags clear",
              16'({tx_overrun, rx_overrun, rx_underrun}), 16'h0);
        check(irq == 1'b0, "R10 irq with masks off", 16'(irq), 16'h0);
    endtask

    task automatic t_fall();
        wr_tx(16'hABC7);
        check(sh_tx_valid == 1'b0, "R1 not at bottom after write edge", 16'(sh_tx_valid), 16'h0);
        settle(6);
        check(sh_tx_valid == 1'b0, "R1 not at bottom after 6 drops", 16'(sh_tx_valid), 16'h0);
        tick();
        check(sh_tx_valid == 1'b1, "R1 at bottom after 7 drops", 16'(sh_tx_valid), 16'h1);
        check(sh_tx_data == 16'hABC7, "R2 word intact", sh_tx_data, 16'hABC7);
        pop_tx();
        check(sh_tx_valid == 1'b0, "R7 pop empties queue", 16'(sh_tx_valid), 16'h0);
        pop_tx();
        wr_tx(16'h0F0E);
        settle(8);
        check(sh_tx_valid == 1'b1 && sh_tx_data == 16'h0F0E, "R7 empty pop had no effect",
              sh_tx_data, 16'h0F0E);
        pop_tx();
        check(tx_overrun == 1'b0, "R6 no overrun yet", 16'(tx_overrun), 16'h0);
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < 8; i++) wr_tx(tx_word(i));
        check(tx_level_flag == 1'b0, "R4 tx flag with 8 held", 16'(tx_level_flag), 16'h0);
        wr_tx(16'hFFFF);
        check(tx_overrun == 1'b1, "R6 overrun on full write", 16'(tx_overrun), 16'h1);
        settle(2);
        for (int i = 0; i < 8; i++) begin
            check(sh_tx_valid == 1'b1 && sh_tx_data == tx_word(i), "R2 tx order",
                  sh_tx_data, tx_word(i));
            pop_tx();
            if (i == 2) check(tx_level_flag == 1'b0, "R4 tx flag with 5 held",
                              16'(tx_level_flag), 16'h0);
            if (i == 3) check(tx_level_flag == 1'b1, "R4 tx flag with 4 held",
                              16'(tx_level_flag), 16'h1);
        end
        check(sh_tx_valid == 1'b0, "R6 dropped word absent", 16'(sh_tx_valid), 16'h0);
        check(tx_overrun == 1'b1, "R6 overrun sticky", 16'(tx_overrun), 16'h1);
    endtask

    task automatic t_rx();
        for (int i = 0; i < 3; i++) push_rx(rx_word(i));
        check(rx_level_flag == 1'b0, "R5 rx flag with 3 held", 16'(rx_level_flag), 16'h0);
        push_rx(rx_word(3));
        check(rx_level_flag == 1'b1, "R5 rx flag with 4 held", 16'(rx_level_flag), 16'h1);
        for (int i = 4; i < 8; i++) push_rx(rx_word(i));
        check(rx_overrun == 1'b0, "R8 no overrun while space", 16'(rx_overrun), 16'h0);
        push_rx(16'hDEAD);
        check(rx_overrun == 1'b1, "R8 overrun on full push", 16'(rx_overrun), 16'h1);
        settle(8);
        host_rd_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            check(host_rd_data == rx_word(i), "R3 back-to-back read order",
                  host_rd_data, rx_word(i));
            if (i == 4) check(rx_level_flag == 1'b0, "R5 rx flag with 3 left",
                              16'(rx_level_flag), 16'h0);
        end
        host_rd_en = 1'b0;
        settle(2);
        check(host_rd_data == rx_word(7), "R3 rd data held without read",
              host_rd_data, rx_word(7));
        check(rx_underrun == 1'b0, "R9 no underrun yet", 16'(rx_underrun), 16'h0);
        rd_rx();
        check(host_rd_data == 16'h0, "R8 R9 empty read returns zero", host_rd_data, 16'h0);
        check(rx_underrun == 1'b1, "R9 underrun set", 16'(rx_underrun), 16'h1);
        settle(3);
        check(rx_underrun == 1'b1, "R9 underrun sticky", 16'(rx_underrun), 16'h1);
    endtask

    task automatic t_irq();
        tx_mask = 1'b1; rx_mask = 1'b0; #1;
        check(irq == 1'b1, "R10 tx flag unmasked", 16'(irq), 16'h1);
        tx_mask = 1'b0; rx_mask = 1'b1; #1;
        check(irq == 1'b0, "R10 rx unmasked but flag low", 16'(irq), 16'h0);
        for (int i = 0; i < 4; i++) push_rx(rx_word(i + 8));
        check(irq == 1'b1, "R10 rx flag unmasked", 16'(irq), 16'h1);
        rx_mask = 1'b0; #1;
        check(irq == 1'b0, "R10 rx flag masked", 16'(irq), 16'h0);
        rx_mask = 1'b1;
        settle(8);
        rd_rx();
        check(irq == 1'b0, "R10 irq follows rx flag down", 16'(irq), 16'h0);
        for (int i = 0; i < 3; i++) rd_rx();
        rx_mask = 1'b0;
    endtask

    initial begin
        settle(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_fall();
        t_tx_full();
        t_rx();
        t_irq();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule